// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block sends one asynchronous serial character at a time on a single transmit line. A character is handed over as a data byte plus an address-bit value through a valid/ready handshake. The block then emits a low start bit, the configured number of data bits (5 to 8, least significant first), an optional address/data marker bit, an optional parity bit, and one or two high stop bits. The start and stop bits always come from the block itself and never from the input data.

Bit timing comes from a single-cycle bit-rate enable (`bit_tick`). That enable can be produced by an internal divider or derived from an external clock. The block only reacts to it and does not generate it. The line moves to its next bit only on a clock edge where the enable is high, so each bit lasts exactly one enable interval. The frame shape is taken from the configuration inputs on the cycle a character is accepted and is held for the whole character. `tx_busy` stays high from acceptance until the final stop bit has completed its interval.

Top module: `uart_char_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1. Whenever the block is idle, `tx_line` stays 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `tx_busy` is 1 from the next cycle. `in_ready` is 0 while busy, and `in_valid`, `in_data` and `in_addr` presented while busy have no effect on the line.
- R3: The first bit after acceptance is a 0 start bit. It is followed by the data bits, bit 0 of `in_data` first.
- R4: `cfg_len` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits at or above the selected width are never sent and do not affect parity.
- R5: When `cfg_addr_en` is 1, the value of `in_addr` is sent as one bit directly after the last data bit. When it is 0, no such bit is sent.
- R6: When `cfg_par_en` is 1, a parity bit follows the address bit (or the data bits if the address bit is absent). The parity bit makes the count of ones over the sent data bits, the address bit if present, and the parity bit itself even when `cfg_par_odd` is 0 and odd when it is 1.
- R7: The frame ends with one stop bit at 1, or two when `cfg_two_stop` is 1.
- R8: `tx_line` changes only in the cycle after an edge where `bit_tick` was 1. Each frame bit is held for exactly one `bit_tick` interval. A `bit_tick` on the accepting edge does not start the start bit.
- R9: The configuration inputs are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R10: `tx_busy` falls on the `bit_tick` edge that ends the last stop bit, and `in_ready` rises with it. A new character can then be accepted at once, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-rate enable, one pulse per bit time |
| cfg_len | input | 2 | Data width code, width = 5 + code |
| cfg_addr_en | input | 1 | Insert the address/data marker bit |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | 8 | Character data, bit 0 sent first |
| in_addr | input | 1 | Value of the address/data marker bit |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A character is in progress |

## Verification
The states hardest to reach from the ports are the ones where unrelated stimulus lands at a sensitive moment. These include a bit tick coinciding with the accepting edge, configuration or a fresh valid character changing in the middle of a frame, and a new character waiting on the very edge that ends the last stop bit. The bench covers these with a tick generator that can run at every cycle, at a fixed divide, or in an irregular pattern. It also holds `in_valid` high with different data across a busy frame, flips every configuration input mid-frame, and queues the next character before the current one finishes. A behavioural bit-queue model is compared against the line, busy and ready outputs on every cycle.

// File: rtl/uart_char_tx_pkg.sv
package uart_char_tx_pkg;
    localparam int DATA_W   = 8;
    localparam int MIN_DATA = 5;
    localparam int STOP_MAX = 2;
    localparam int FRAME_W  = 1 + DATA_W + 1 + 1 + STOP_MAX;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int LEN_W    = $clog2(DATA_W - MIN_DATA + 1);

    typedef struct packed {
        logic [LEN_W-1:0] len_code;
        logic             addr_en;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } tx_cfg_t;
endpackage

// File: rtl/uart_char_tx_framer.sv
module uart_char_tx_framer
    import uart_char_tx_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    input  logic               addr_i,
    input  tx_cfg_t            cfg_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   count_o
);
    logic [DATA_W-1:0] masked;
    logic              par_bit;

    always_comb begin
        int nbits;
        nbits = MIN_DATA + int'(cfg_i.len_code);
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = (i < nbits) ? data_i[i] : 1'b0;
        end
        par_bit = (^masked) ^ (cfg_i.addr_en & addr_i) ^ cfg_i.par_odd;
    end

    always_comb begin
        int pos;
        frame_o    = '1;
        frame_o[0] = 1'b0;
        pos        = 1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_DATA + int'(cfg_i.len_code)) begin
                frame_o[pos] = data_i[i];
                pos          = pos + 1;
            end
        end
        if (cfg_i.addr_en) begin
            frame_o[pos] = addr_i;
            pos          = pos + 1;
        end
        if (cfg_i.par_en) begin
            frame_o[pos] = par_bit;
            pos          = pos + 1;
        end
        pos     = pos + 1 + (cfg_i.two_stop ? 1 : 0);
        count_o = CNT_W'(pos);
    end
endmodule

// File: rtl/uart_char_tx_shifter.sv
module uart_char_tx_shifter
    import uart_char_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [CNT_W-1:0]   load_count,
    output logic               line,
    output logic               busy
);
    typedef struct packed {
        logic               active;
        logic               tx;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
    } shift_state_t;

    shift_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.active) begin
            s_d.tx = 1'b1;
            if (load) begin
                s_d.active = 1'b1;
                s_d.frame  = load_frame;
                s_d.left   = load_count;
            end
        end else if (bit_tick) begin
            if (s_q.left != '0) begin
                s_d.tx    = s_q.frame[0];
                s_d.frame = {1'b1, s_q.frame[FRAME_W-1:1]};
                s_d.left  = s_q.left - 1'b1;
            end else begin
                s_d.active = 1'b0;
                s_d.tx     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.active <= 1'b0;
            s_q.tx     <= 1'b1;
            s_q.frame  <= '1;
            s_q.left   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line = s_q.tx;
    assign busy = s_q.active;

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> s_q.tx);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !s_q.active) |=> s_q.active);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !bit_tick) |=> $stable(s_q.tx));

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !bit_tick) |=> ($stable(s_q.frame) && $stable(s_q.left)));

    // R10
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !bit_tick) |=> s_q.active);
endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
    import uart_char_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_addr_en,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_addr,
    output logic              tx_line,
    output logic              tx_busy
);
    tx_cfg_t            cfg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   count;
    logic               accept;

    always_comb begin
        cfg.len_code = cfg_len;
        cfg.addr_en  = cfg_addr_en;
        cfg.par_en   = cfg_par_en;
        cfg.par_odd  = cfg_par_odd;
        cfg.two_stop = cfg_two_stop;
    end

    assign in_ready = !tx_busy;
    assign accept   = in_valid && in_ready;

    uart_char_tx_framer u_framer (
        .data_i  (in_data),
        .addr_i  (in_addr),
        .cfg_i   (cfg),
        .frame_o (frame),
        .count_o (count)
    );

    uart_char_tx_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .load       (accept),
        .load_frame (frame),
        .load_count (count),
        .line       (tx_line),
        .busy       (tx_busy)
    );
endmodule

// File: tb/uart_char_tx_tb.sv
module uart_char_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_addr_en = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_addr = 1'b0;
    logic       tx_line;
    logic       tx_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_mode = 1;
    int tick_div = 4;
    int tick_cnt = 0;
    string tag = "R1 reset";

    bit m_tx = 1'b1;
    bit m_busy = 1'b0;
    bit q[$];

    always #4 clk = ~clk;

    uart_char_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .cfg_len(cfg_len), .cfg_addr_en(cfg_addr_en), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_addr(in_addr), .tx_line(tx_line), .tx_busy(tx_busy)
    );

    // Reference model: builds the frame as a bit queue at acceptance
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = 1'b1; m_busy = 1'b0; q.delete();
        end else if (m_busy) begin
            if (bit_tick) begin
                if (q.size() > 0) m_tx = q.pop_front();
                else begin m_busy = 1'b0; m_tx = 1'b1; end
            end
        end else if (in_valid) begin
            int n; bit p;
            n = 5 + int'(cfg_len);
            p = cfg_par_odd;
            q.push_back(1'b0);
            for (int i = 0; i < n; i++) begin q.push_back(in_data[i]); p ^= in_data[i]; end
            if (cfg_addr_en) begin q.push_back(in_addr); p ^= in_addr; end
            if (cfg_par_en) q.push_back(p);
            q.push_back(1'b1);
            if (cfg_two_stop) q.push_back(1'b1);
            m_busy = 1'b1;
        end
    end

    // Bit tick generator: 0 = every cycle, 1 = divided, 2 = irregular
    always @(negedge clk) begin
        #1;
        tick_cnt++;
        case (tick_mode)
            0: bit_tick = 1'b1;
            1: bit_tick = (tick_cnt % tick_div) == 0;
            default: bit_tick = ((tick_cnt * 7) % 5) < 2;
        endcase
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (tx_line !== m_tx || tx_busy !== m_busy || in_ready !== !m_busy) begin
                errors++;
                $display("FAIL %s: line=%0b busy=%0b ready=%0b expected line=%0b busy=%0b ready=%0b",
                         tag, tx_line, tx_busy, in_ready, m_tx, m_busy, !m_busy);
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cfg_set(input [1:0] len, input bit a, input bit pe, input bit po, input bit ts);
        cfg_len = len; cfg_addr_en = a; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    endtask

    task automatic send(input [7:0] d, input bit a);
        @(negedge clk); #2;
        while (!in_ready) begin @(negedge clk); #2; end
        in_data = d; in_addr = a; in_valid = 1'b1;
        @(negedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk); #2;
        while (tx_busy) begin @(negedge clk); #2; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        checks++;
        if (tx_line !== 1'b1 || tx_busy !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: line=%0b busy=%0b ready=%0b expected 1 0 1", tx_line, tx_busy, in_ready);
        end
        #2 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        tag = "R3 eight bits lsb first";
        cfg_set(2'd3, 0, 0, 0, 0); send(8'hA5, 0); wait_idle();
        tag = "R4 width 5 upper ignored";
        cfg_set(2'd0, 0, 1, 0, 0); send(8'hE2, 0); wait_idle();
        tag = "R4 width 6";
        cfg_set(2'd1, 0, 0, 0, 0); send(8'hFF, 0); wait_idle();
        tag = "R4 width 7";
        cfg_set(2'd2, 0, 1, 1, 0); send(8'hC3, 0); wait_idle();
        tag = "R5 address bit one";
        cfg_set(2'd3, 1, 0, 0, 0); send(8'h3C, 1); wait_idle();
        tag = "R5 address bit zero";
        send(8'h3C, 0); wait_idle();
        tag = "R6 even parity with address";
        cfg_set(2'd3, 1, 1, 0, 0); send(8'h01, 1); wait_idle();
        tag = "R6 odd parity with address";
        cfg_set(2'd3, 1, 1, 1, 0); send(8'h07, 1); wait_idle();
        tag = "R6 odd parity no address";
        cfg_set(2'd3, 0, 1, 1, 0); send(8'h00, 0); wait_idle();
        tag = "R7 two stop bits";
        cfg_set(2'd3, 0, 1, 0, 1); send(8'h5A, 0); wait_idle();

        tag = "R8 tick every cycle";
        tick_mode = 0;
        cfg_set(2'd3, 1, 1, 0, 1); send(8'h96, 1); wait_idle();
        tag = "R8 irregular tick";
        tick_mode = 2;
        cfg_set(2'd1, 1, 1, 1, 0); send(8'h2B, 0); wait_idle();
        tick_mode = 1; tick_div = 6;

        tag = "R2 valid held while busy";
        cfg_set(2'd3, 0, 1, 0, 0);
        send(8'h81, 0);
        in_valid = 1'b1; in_data = 8'h7E; in_addr = 1'b1;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();

        tag = "R9 config changed mid frame";
        cfg_set(2'd3, 0, 0, 0, 0); send(8'hF0, 0);
        repeat (9) @(negedge clk);
        cfg_set(2'd0, 1, 1, 1, 1);
        wait_idle();

        tag = "R10 back to back";
        cfg_set(2'd2, 0, 1, 0, 0);
        send(8'h11, 0); send(8'h6D, 0); send(8'h40, 0);
        wait_idle();
        tick_mode = 0;
        send(8'h55, 0); send(8'hAA, 0);
        wait_idle();

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule